// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a processor reach a bank of sixteen byte-wide internal registers through two bus-visible registers. One is a control register that holds the target address, a few mode flags and a busy flag. The other is a data register that holds the byte to be written, or the byte most recently fetched. Writing the data register starts an internal write. A read starts when software writes 1 to the busy flag, or, if the auto-read mode is on, when software reads the data register. Each internal access drives a read or write strobe on the register-file port. The strobe is held for four clocks in normal mode and for one clock in fast mode.

Two six-byte ranges hold the multi-byte timer fields: addresses 0x0-0x5 and 0x8-0xD. After any access inside these ranges the address steps forward by one, so a whole field can be streamed without rewriting the address. An external guard supplies an enable input. While that input is low no access is started, and each attempt raises a one-cycle invalid-access pulse. The mode flags, the address and the data byte have no reset and keep their values through a reset. Only the busy state and the strobes are cleared.

Top module: `regfile_bridge`

## Requirements
- R1: With `bus_sel_i`=0, `bus_rdata_o` shows the control register: bit 7 busy, bit 6 auto-read, bit 5 supply-regulator flag, bit 4 fast mode, bits 3:0 address. With `bus_sel_i`=1 it shows the data byte. A bus write to the control register updates bits 6:0.
- R2: When idle and enabled, a bus write with `bus_sel_i`=1 loads the byte into the data register. It then drives `rf_wr_o` with `rf_addr_o` equal to the address field and `rf_wdata_o` equal to the byte.
- R3: When idle and enabled, a control write with bit 7 set starts a read of the address it writes. When the read ends, the data register holds that internal register's value. The value stays until the next access, and plain data-register reads do not change it.
- R4: The busy bit reads 1 from the clock after a start until the access ends, and reads 0 after that. `rf_wr_o` and `rf_rd_o` are never high together.
- R5: A strobe stays high for 4 clocks when the fast bit was 0 at the start, and for 1 clock when it was 1.
- R6: With auto-read set, a bus read of the data register while idle returns the current byte and starts a read of the current address.
- R7: An access that ends at address 0x0-0x5 or 0x8-0xD increments the address field by one. Any other address is left as it is. The mode flags never change on increment.
- R8: While busy, bus writes to either register and auto-read triggers are ignored. No register changes and no further access starts.
- R9: While `enable_i` is 0, no access starts and busy stays 0. Every start attempt gives `invalid_o`=1 on the following clock. A blocked data write leaves the data byte unchanged. A blocked control write still updates bits 6:0.
- R10: A low `rst_ni` clears busy, both strobes and `invalid_o`. Control bits 6:0 and the data byte keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Access permission from the guard |
| bus_sel_i | input | 1 | 0 selects the control register, 1 selects the data register |
| bus_wr_i | input | 1 | Bus write strobe, one cycle |
| bus_rd_i | input | 1 | Bus read strobe, one cycle |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Selected register contents |
| invalid_o | output | 1 | Start attempted while disabled |
| rf_addr_o | output | 4 | Internal register address |
| rf_wdata_o | output | 8 | Internal write data |
| rf_wr_o | output | 1 | Internal write strobe |
| rf_rd_o | output | 1 | Internal read strobe |
| rf_rdata_i | input | 8 | Internal read data |

## Verification
The bound checker watches every cycle for the following:
- the strobes are exclusive, and each run lasts either 1 or 4 cycles;
- the address and write data stay stable while a strobe is held;
- every strobe rise traces back to a legal start while enabled;
- the address steps inside the field ranges and holds outside them;
- the outputs are cleared under reset.

Several behaviours need the bench's directed scenarios, checked against its cycle-level reference model:
- the value captured by a read, and the stale value returned by an auto-read;
- that writes made while busy are dropped;
- that the flags and data survive a reset pulse;
- the edge addresses 0x5, 0x7, 0xD, 0xE and 0xF.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 4;

  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} xfer_op_e;

  // control register bits 6:0; bit 7 is the live busy flag
  typedef struct packed {
    logic              auto_rd;
    logic              bkp_en;
    logic              fast;
    logic [ADDR_W-1:0] addr;
  } ctrl_t;

  function automatic logic in_field(logic [ADDR_W-1:0] a, int cap, int alm, int len);
    int ai;
    ai = int'(a);
    return ((ai >= cap) && (ai < cap + len)) || ((ai >= alm) && (ai < alm + len));
  endfunction
endpackage

// File: rtl/rfb_bus_decode.sv
module rfb_bus_decode import rfb_pkg::*; (
  input  logic     busy_i,
  input  logic     enable_i,
  input  logic     auto_rd_i,
  input  logic     bus_sel_i,
  input  logic     bus_wr_i,
  input  logic     bus_rd_i,
  input  logic     go_bit_i,
  output logic     ctrl_we_o,
  output logic     data_we_o,
  output logic     start_o,
  output xfer_op_e start_op_o,
  output logic     invalid_o
);
  logic try_rd_ctrl, try_rd_auto, try_wr, attempt;

  always_comb begin
    try_rd_ctrl = !busy_i && bus_wr_i && !bus_sel_i && go_bit_i;
    try_rd_auto = !busy_i && !bus_wr_i && bus_rd_i && bus_sel_i && auto_rd_i;
    try_wr      = !busy_i && bus_wr_i && bus_sel_i;
    attempt     = try_rd_ctrl || try_rd_auto || try_wr;

    ctrl_we_o   = !busy_i && bus_wr_i && !bus_sel_i;
    data_we_o   = try_wr && enable_i;
    start_o     = attempt && enable_i;
    start_op_o  = try_wr ? OP_WR : OP_RD;
    invalid_o   = attempt && !enable_i;
  end
endmodule

// File: rtl/rfb_xfer_timer.sv
module rfb_xfer_timer import rfb_pkg::*; #(
  parameter int LONG_CYCLES = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     fast_i,
  input  xfer_op_e op_i,
  output logic     busy_o,
  output xfer_op_e op_o,
  output logic     done_o
);
  localparam int CNT_W = (LONG_CYCLES > 1) ? $clog2(LONG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  xfer_op_e         op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_RD;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= fast_i ? '0 : LONG_LAST;
      op_q   <= op_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/rfb_addr_step.sv
module rfb_addr_step #(
  parameter int ADDR_W    = 4,
  parameter int CAP_BASE  = 0,
  parameter int ALM_BASE  = 8,
  parameter int FIELD_LEN = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int NUM_FIELDS = 2;
  logic [NUM_FIELDS-1:0] hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int BASE = (g == 0) ? CAP_BASE : ALM_BASE;
    assign hit[g] = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + FIELD_LEN);
  end

  assign addr_o = (|hit) ? addr_i + ADDR_W'(1) : addr_i;
endmodule

// File: rtl/regfile_bridge.sv
module regfile_bridge import rfb_pkg::*; #(
  parameter int LONG_CYCLES = 4,
  parameter int CAP_BASE    = 0,
  parameter int ALM_BASE    = 8,
  parameter int FIELD_LEN   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              invalid_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              rf_wr_o,
  output logic              rf_rd_o,
  input  logic [DATA_W-1:0] rf_rdata_i
);
  localparam int GO_BIT   = DATA_W - 1;
  localparam int FAST_BIT = ADDR_W;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] data_q;
  logic              invalid_q;
  logic              busy, done, ctrl_we, data_we, start, inval_d, start_fast;
  xfer_op_e          start_op, cur_op;
  logic [ADDR_W-1:0] addr_next;

  rfb_bus_decode u_decode (
    .busy_i     (busy),
    .enable_i   (enable_i),
    .auto_rd_i  (ctrl_q.auto_rd),
    .bus_sel_i  (bus_sel_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .go_bit_i   (bus_wdata_i[GO_BIT]),
    .ctrl_we_o  (ctrl_we),
    .data_we_o  (data_we),
    .start_o    (start),
    .start_op_o (start_op),
    .invalid_o  (inval_d)
  );

  // a control write takes effect at the start edge, so its fast bit rules
  assign start_fast = ctrl_we ? bus_wdata_i[FAST_BIT] : ctrl_q.fast;

  rfb_xfer_timer #(.LONG_CYCLES(LONG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .fast_i  (start_fast),
    .op_i    (start_op),
    .busy_o  (busy),
    .op_o    (cur_op),
    .done_o  (done)
  );

  rfb_addr_step #(
    .ADDR_W    (ADDR_W),
    .CAP_BASE  (CAP_BASE),
    .ALM_BASE  (ALM_BASE),
    .FIELD_LEN (FIELD_LEN)
  ) u_step (
    .addr_i (ctrl_q.addr),
    .addr_o (addr_next)
  );

  // control and data registers retain contents across reset
  always_ff @(posedge clk_i) begin
    if (ctrl_we)   ctrl_q      <= ctrl_t'(bus_wdata_i[DATA_W-2:0]);
    else if (done) ctrl_q.addr <= addr_next;
  end

  always_ff @(posedge clk_i) begin
    if (data_we)                     data_q <= bus_wdata_i;
    else if (done && cur_op == OP_RD) data_q <= rf_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) invalid_q <= 1'b0;
    else         invalid_q <= inval_d;
  end

  assign bus_rdata_o = bus_sel_i ? data_q : {busy, ctrl_q};
  assign invalid_o   = invalid_q;
  assign rf_addr_o   = ctrl_q.addr;
  assign rf_wdata_o  = data_q;
  assign rf_wr_o     = busy && (cur_op == OP_WR);
  assign rf_rd_o     = busy && (cur_op == OP_RD);
endmodule

// File: rtl/rfb_bridge_chk.sv
module rfb_bridge_chk import rfb_pkg::*; #(
  parameter int LONG_CYCLES = 4,
  parameter int CAP_BASE    = 0,
  parameter int ALM_BASE    = 8,
  parameter int FIELD_LEN   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic              go_bit_i,
  input logic              invalid_i,
  input logic [ADDR_W-1:0] rf_addr_i,
  input logic [DATA_W-1:0] rf_wdata_i,
  input logic              rf_wr_i,
  input logic              rf_rd_i
);
  logic       act;
  logic [7:0] run_len;

  assign act = rf_wr_i || rf_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  run_len <= '0;
    else if (act) run_len <= (run_len == 8'hFF) ? run_len : run_len + 8'd1;
    else          run_len <= '0;
  end

  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_wr_i && rf_rd_i));

  assert_run_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act) |-> (run_len == 8'd1 || run_len == 8'(LONG_CYCLES)));

  assert_wr_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rf_wr_i) |-> $past(bus_wr_i && bus_sel_i && enable_i));

  assert_rd_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rf_rd_i) |-> $past(enable_i && ((bus_wr_i && !bus_sel_i && go_bit_i) ||
                                          (!bus_wr_i && bus_rd_i && bus_sel_i))));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && $past(act)) |-> ($stable(rf_addr_i) && $stable(rf_wdata_i)));

  assert_step_in_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(act) && in_field($past(rf_addr_i), CAP_BASE, ALM_BASE, FIELD_LEN))
      |-> (rf_addr_i == $past(rf_addr_i) + ADDR_W'(1)));

  assert_step_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(act) && !in_field($past(rf_addr_i), CAP_BASE, ALM_BASE, FIELD_LEN))
      |-> (rf_addr_i == $past(rf_addr_i)));

  assert_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && bus_wr_i && bus_sel_i && !act) |=> (invalid_i && !act));

  assert_reset_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (!rf_wr_i && !rf_rd_i && !invalid_i));
endmodule

bind regfile_bridge rfb_bridge_chk #(
  .LONG_CYCLES (LONG_CYCLES),
  .CAP_BASE    (CAP_BASE),
  .ALM_BASE    (ALM_BASE),
  .FIELD_LEN   (FIELD_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .bus_sel_i  (bus_sel_i),
  .bus_wr_i   (bus_wr_i),
  .bus_rd_i   (bus_rd_i),
  .go_bit_i   (bus_wdata_i[7]),
  .invalid_i  (invalid_o),
  .rf_addr_i  (rf_addr_o),
  .rf_wdata_i (rf_wdata_o),
  .rf_wr_i    (rf_wr_o),
  .rf_rd_i    (rf_rd_o)
);

// File: tb/regfile_bridge_tb_top.sv
module regfile_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LONG       = 4;
  localparam int WD_LIMIT   = 20000;

  logic       clk = 1'b0, rst_ni = 1'b1, enable = 1'b1;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, rf_wdata, rf_rdata;
  logic [3:0] rf_addr;
  logic       invalid, rf_wr, rf_rd;
  logic [7:0] rf [16];

  int total = 0, fails = 0, cyc = 0;
  bit ended = 1'b0;

  regfile_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .invalid_o(invalid),
    .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata), .rf_wr_o(rf_wr),
    .rf_rd_o(rf_rd), .rf_rdata_i(rf_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // register-file model
  initial for (int i = 0; i < 16; i++) rf[i] = 8'h30 + 8'(i);
  assign rf_rdata = rf[rf_addr];
  always @(posedge clk) if (rf_wr) rf[rf_addr] <= rf_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !ended) begin
      total++; fails++;
      $display("FAIL R4 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // behavioural reference model
  bit       m_busy = 0, m_wr = 0, m_inv = 0, m_ck = 0, m_dk = 0;
  int       m_left = 0;
  bit [6:0] m_ctrl = '0;
  bit [7:0] m_data = '0;

  function automatic bit steps(int a);
    return (a >= 0 && a <= 5) || (a >= 8 && a <= 13);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_left = 0; m_inv = 0;
    end else begin
      bit inv_n;
      bit try;
      inv_n = 0;
      if (m_busy) begin
        if (m_left == 0) begin
          m_busy = 0;
          if (!m_wr) begin m_data = rf[m_ctrl[3:0]]; m_dk = 1; end
          if (steps(int'(m_ctrl[3:0]))) m_ctrl[3:0] = m_ctrl[3:0] + 4'd1;
        end else m_left--;
      end else begin
        try = 0;
        if (wr && !sel) begin
          m_ctrl = wdata[6:0]; m_ck = 1;
          if (wdata[7]) begin try = 1; m_wr = 0; end
        end else if (wr && sel) begin
          try = 1; m_wr = 1;
          if (enable) begin m_data = wdata; m_dk = 1; end
        end else if (rd && sel && m_ctrl[6]) begin
          try = 1; m_wr = 0;
        end
        if (try) begin
          if (enable) begin m_busy = 1; m_left = m_ctrl[4] ? 0 : LONG - 1; end
          else inv_n = 1;
        end
      end
      m_inv = inv_n;
    end
  end

  // per-cycle comparison, away from both edges and stimulus updates
  always @(negedge clk) begin
    #2;
    if (!ended) begin
      chk("R4 rd strobe", rf_rd, m_busy && !m_wr);
      chk("R2 wr strobe", rf_wr, m_busy && m_wr);
      chk("R9 invalid", invalid, m_inv);
      if (m_ck) chk("R7 addr", rf_addr, m_ctrl[3:0]);
      if (m_busy && m_wr) chk("R2 wdata", rf_wdata, m_data);
      if (!sel && m_ck) chk("R1 ctrl view", rdata, {m_busy, m_ctrl});
      if (sel && m_dk) chk("R3 data view", rdata, m_data);
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic bwr(input logic s, input logic [7:0] v);
    sel = s; wr = 1'b1; wdata = v;
    tick();
    wr = 1'b0;
  endtask

  task automatic brd(input logic s, output logic [7:0] v);
    sel = s; rd = 1'b1; #1;
    v = rdata;
    tick();
    rd = 1'b0;
  endtask

  task automatic peek(input logic s, output logic [7:0] v);
    sel = s; #1;
    v = rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while ((rf_wr || rf_rd) && n < 100) begin n++; tick(); end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    int av [5] = '{13, 14, 5, 7, 15};
    int ae [5] = '{14, 14, 6, 7, 15};

    #1 rst_ni = 1'b0;
    tick(); tick(); tick();
    peek(0, v);
    chk("R10 busy in reset", v[7], 1'b0);
    chk("R10 strobes in reset", {rf_wr, rf_rd}, 2'b00);
    chk("R10 invalid in reset", invalid, 1'b0);
    rst_ni = 1'b1;
    tick();

    // slow write at start of capture field
    bwr(0, 8'h00);
    peek(0, v); chk("R1 ctrl readback", v, 8'h00);
    bwr(1, 8'h5A);
    peek(0, v); chk("R4 busy set", v[7], 1'b1);
    wait_idle(n); chk("R5 slow length", n, LONG);
    peek(0, v); chk("R4 busy cleared / R7 step", v, 8'h01);
    chk("R2 stored byte", rf[0], 8'h5A);

    // fast read by busy bit outside the fields
    bwr(0, 8'h96);
    wait_idle(n); chk("R5 fast length", n, 1);
    peek(1, v); chk("R3 captured", v, 8'h36);
    peek(0, v); chk("R7 no step at 6", v, 8'h16);
    brd(1, v); chk("R3 hold", v, 8'h36);
    chk("R3 no autoread when off", rf_rd, 1'b0);
    brd(1, v); chk("R3 hold again", v, 8'h36);

    // auto-read streaming through alarm field
    bwr(0, 8'h58);
    brd(1, v); chk("R6 returns prior byte", v, 8'h36);
    chk("R6 read started", rf_rd, 1'b1);
    wait_idle(n);
    peek(1, v); chk("R6 fetched", v, 8'h38);
    peek(0, v); chk("R7 step in alarm", v, 8'h59);
    brd(1, v); chk("R6 second prior", v, 8'h38);
    wait_idle(n);
    peek(1, v); chk("R6 second fetch", v, 8'h39);

    // writes while busy are dropped
    bwr(0, 8'h03);
    bwr(1, 8'h11);
    bwr(1, 8'h22);
    bwr(0, 8'h8C);
    wait_idle(n);
    chk("R8 stored byte", rf[3], 8'h11);
    peek(1, v); chk("R8 data kept", v, 8'h11);
    peek(0, v); chk("R8 ctrl kept", v, 8'h04);

    // disabled by guard
    enable = 1'b0;
    bwr(0, 8'h9E);
    chk("R9 invalid after read try", invalid, 1'b1);
    chk("R9 no strobe", rf_rd, 1'b0);
    peek(0, v); chk("R9 fields taken", v, 8'h1E);
    tick(); chk("R9 pulse ends", invalid, 1'b0);
    bwr(1, 8'h77);
    chk("R9 invalid after write try", invalid, 1'b1);
    peek(1, v); chk("R9 data unchanged", v, 8'h11);
    bwr(0, 8'h5E);
    chk("R9 no try no pulse", invalid, 1'b0);
    brd(1, v);
    chk("R9 autoread blocked", invalid, 1'b1);
    chk("R9 autoread no strobe", rf_rd, 1'b0);

    // retention through reset
    enable = 1'b1;
    bwr(0, 8'h1A);
    rst_ni = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    peek(0, v); chk("R10 ctrl retained", v, 8'h1A);
    peek(1, v); chk("R10 data retained", v, 8'h11);

    // field edges
    for (int i = 0; i < 5; i++) begin
      bwr(0, 8'h10 | 8'(av[i]));
      bwr(1, 8'hC0 | 8'(av[i]));
      wait_idle(n);
      peek(0, v); chk("R7 edge step", v, 8'h10 | 8'(ae[i]));
    end

    tick(); tick();
    finish_run();
  end
endmodule